// File: doc/BRIEF.md
# Debug Register Access Unit

This block holds the debug register space of a processor core: four 32-bit breakpoint address registers, a breakpoint status register and a breakpoint control register, reached through eight slot numbers. It serves the instructions that move a value into a debug register or copy one out to a general register. The instruction decoder hands over the operand-form byte, the current mode, the privilege level, the debug-extension bit of the feature control register and the value to write. The unit decides whether the access is allowed and then either performs it or reports one exception code.

An accepted request is finished one clock later. In that cycle `done` pulses, and `rd_data`, `exc_code` and `gpr_sel` are valid. The unit also keeps a 4-bit vector that marks which breakpoints are armed, and it recomputes that vector on each write to the control register. The status read view depends on the `FAMILY` parameter: family 4 or family 5 and later.

Top module: `debug_reg_unit`

## Requirements
- R1: A request taken on a clock edge (`req_valid` high) gives `done` high for exactly the following cycle, with `rd_data` and `exc_code` valid in that cycle. `rd_data` is 0 for writes and for requests that raise an exception. Exception codes: 0 none, 1 invalid opcode, 2 general protection, 3 debug.
- R2: An operand-form byte below 0xC0 gives code 1. The slot is bits 5:3 of the byte.
- R3: With `prot_mode` high, a request made with `v86_mode` high or with `cpl` other than 0 gives code 2. Outside protected mode, `cpl` and `v86_mode` have no effect.
- R4: If control bit 13 (general detect) is set, the request gives code 3. The unit also sets status bit 13, clears control bit 13 and transfers no data.
- R5: Slots 0 to 3 store and return all 32 bits unchanged.
- R6: Slot 4 acts as the status register and slot 5 as the control register. When `FAMILY` >= 5 and `de_ext` is high, an access to slot 4 or 5 gives code 1.
- R7: A status read returns (status & 0x0000E00F) | 0xFFFF0FF0 when `FAMILY` >= 5, and (status & 0x0000F00F) | 0xFFFF0FF0 when `FAMILY` is 4.
- R8: A status write stores the full 32-bit value.
- R9: A control write stores all 32 bits and sets `bp_active[i]` to control bit 2i OR control bit 2i+1. `bp_active` is updated in the same cycle that `done` pulses, and it changes at no other time.
- R10: The checks are applied in a fixed priority order: register form, then privilege, then general detect, then the slot-4/5 check. Only the first check that fails is reported.
- R11: A request that raises an exception modifies no register, apart from the side effects of R4.
- R12: After reset, all registers and `bp_active` are 0 and `done` is low.
- R13: `gpr_sel` returns bits 2:0 of the operand-form byte, valid with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_is_write | input | 1 | 1 = move into a debug register, 0 = move out |
| modrm | input | 8 | Operand-form byte |
| prot_mode | input | 1 | Protected mode active |
| v86_mode | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| de_ext | input | 1 | Debug-extension bit of the feature control register |
| wr_data | input | 32 | Value to write |
| done | output | 1 | Request finished this cycle |
| rd_data | output | 32 | Value read |
| exc_code | output | 2 | Exception code |
| gpr_sel | output | 3 | General register selected by the request |
| bp_active | output | 4 | Breakpoints enabled locally or globally |

## Verification
The bench builds two instances side by side and drives both with the same stimulus. One uses `FAMILY` = 5 and the other `FAMILY` = 4. Running them together shows the two status read masks on identical register contents. It also shows that with `de_ext` high the slot-4 access traps on the newer family and still reaches the status register on the older one.

// File: rtl/debug_reg_unit.sv
module debug_reg_unit #(
  parameter int FAMILY = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_is_write,
  input  logic [7:0]  modrm,
  input  logic        prot_mode,
  input  logic        v86_mode,
  input  logic [1:0]  cpl,
  input  logic        de_ext,
  input  logic [31:0] wr_data,
  output logic        done,
  output logic [31:0] rd_data,
  output logic [1:0]  exc_code,
  output logic [2:0]  gpr_sel,
  output logic [3:0]  bp_active
);
  localparam int NBP = 4;
  localparam logic [31:0] STS_KEEP = (FAMILY >= 5) ? 32'h0000_E00F : 32'h0000_F00F;
  localparam logic [31:0] STS_ONES = 32'hFFFF_0FF0;
  localparam int GD_BIT = 13;
  localparam logic [1:0] EXC_NONE = 2'd0, EXC_UD = 2'd1, EXC_GP = 2'd2, EXC_DB = 2'd3;

  logic [31:0] bp_addr [NBP];
  logic [31:0] sts, ctl;
  logic [2:0]  slot, slot_q;
  logic        wr_q;
  logic        reg_form, priv_bad, alias_bad, is_sts, is_ctl;
  logic [1:0]  exc_n;
  logic [31:0] rd_val;
  logic [NBP-1:0] bp_n;

  assign slot      = modrm[5:3];
  assign reg_form  = modrm >= 8'hC0;
  assign priv_bad  = prot_mode && (v86_mode || cpl != 2'd0);
  assign is_sts    = (slot == 3'd4) || (slot == 3'd6);
  assign is_ctl    = (slot == 3'd5) || (slot == 3'd7);
  assign alias_bad = (FAMILY >= 5) && de_ext && (slot == 3'd4 || slot == 3'd5);

  always_comb begin
    if (!reg_form)        exc_n = EXC_UD;
    else if (priv_bad)    exc_n = EXC_GP;
    else if (ctl[GD_BIT]) exc_n = EXC_DB;
    else if (alias_bad)   exc_n = EXC_UD;
    else                  exc_n = EXC_NONE;
  end

  always_comb begin
    if (!slot[2])    rd_val = bp_addr[slot[1:0]];
    else if (is_sts) rd_val = (sts & STS_KEEP) | STS_ONES;
    else             rd_val = ctl;
  end

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    assign bp_n[i] = wr_data[2*i] | wr_data[2*i+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBP; i++) bp_addr[i] <= '0;
      sts       <= '0;
      ctl       <= '0;
      bp_active <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      exc_code  <= EXC_NONE;
      gpr_sel   <= '0;
      slot_q    <= '0;
      wr_q      <= 1'b0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        exc_code <= exc_n;
        gpr_sel  <= modrm[2:0];
        slot_q   <= slot;
        wr_q     <= req_is_write;
        rd_data  <= (exc_n == EXC_NONE && !req_is_write) ? rd_val : '0;
        if (exc_n == EXC_DB) begin
          sts[GD_BIT] <= 1'b1;
          ctl[GD_BIT] <= 1'b0;
        end else if (exc_n == EXC_NONE && req_is_write) begin
          if (!slot[2]) bp_addr[slot[1:0]] <= wr_data;
          else if (is_sts) sts <= wr_data;
          else if (is_ctl) begin
            ctl       <= wr_data;
            bp_active <= bp_n;
          end
        end
      end
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  // R2
  ud_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && modrm < 8'hC0 |=> exc_code == EXC_UD);
  // R3
  gp_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && modrm >= 8'hC0 && prot_mode && (v86_mode || cpl != 2'd0) |=> exc_code == EXC_GP);
  // R4
  gd_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !priv_bad && reg_form && ctl[GD_BIT] |=> exc_code == EXC_DB && !ctl[GD_BIT] && sts[GD_BIT]);
  // R7
  sts_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc_code == EXC_NONE && !wr_q && (slot_q == 3'd4 || slot_q == 3'd6)
      |-> rd_data[31:16] == 16'hFFFF && rd_data[11:4] == 8'hFF);
  // R9
  bp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_active) |-> $past(req_valid && req_is_write));
endmodule

// File: tb/test_debug_reg_unit.sv
module test_debug_reg_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_write = 0, prot_mode = 0, v86_mode = 0, de_ext = 0;
  logic [7:0] modrm = 0;
  logic [1:0] cpl = 0;
  logic [31:0] wr_data = 0;
  logic done5, done4;
  logic [31:0] rd5, rd4;
  logic [1:0] exc5, exc4;
  logic [2:0] gs5, gs4;
  logic [3:0] bp5, bp4;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  debug_reg_unit #(.FAMILY(5)) i_debug_reg_unit (
    .clk, .rst_n, .req_valid, .req_is_write, .modrm, .prot_mode, .v86_mode, .cpl, .de_ext,
    .wr_data, .done(done5), .rd_data(rd5), .exc_code(exc5), .gpr_sel(gs5), .bp_active(bp5));
  debug_reg_unit #(.FAMILY(4)) i_debug_reg_unit_f4 (
    .clk, .rst_n, .req_valid, .req_is_write, .modrm, .prot_mode, .v86_mode, .cpl, .de_ext,
    .wr_data, .done(done4), .rd_data(rd4), .exc_code(exc4), .gpr_sel(gs4), .bp_active(bp4));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] mr(int slot, int gpr);
    return 8'hC0 | 8'(slot << 3) | 8'(gpr);
  endfunction

  task automatic req(bit wr, logic [7:0] m, logic [31:0] d, bit pm = 0, bit vm = 0,
                     logic [1:0] pl = 0, bit de = 0);
    @(negedge clk);
    req_valid = 1; req_is_write = wr; modrm = m; wr_data = d;
    prot_mode = pm; v86_mode = vm; cpl = pl; de_ext = de;
    @(negedge clk);
    req_valid = 0; req_is_write = 0; prot_mode = 0; v86_mode = 0; cpl = 0; de_ext = 0;
    check("R1 done", {done5, done4}, 2'b11);
  endtask

  task automatic t_reset();
    check("R12 done low", {done5, done4}, 0);
    check("R12 bp_active", {bp5, bp4}, 0);
    req(0, mr(7, 0), 0);
    check("R12 ctl zero", rd5, 0);
    req(0, mr(6, 0), 0);
    check("R12 sts view f5", rd5, 32'hFFFF0FF0);
    check("R12 sts view f4", rd4, 32'hFFFF0FF0);
    @(negedge clk);
    check("R1 done drops", {done5, done4}, 0);
  endtask

  task automatic t_bp_regs();
    req(1, mr(2, 3), 32'hA5A5_5A5A);
    check("R1 write rd zero", rd5, 0);
    check("R1 write exc none", exc5, 0);
    req(0, mr(2, 5), 0);
    check("R5 slot2 readback", rd5, 32'hA5A5_5A5A);
    check("R13 gpr_sel", gs5, 3'd5);
    req(1, mr(0, 0), 32'hFFFF_FFFF);
    req(0, mr(0, 1), 0);
    check("R5 slot0 readback", rd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_status();
    req(1, mr(6, 0), 32'hFFFF_FFFF);
    req(0, mr(6, 0), 0);
    check("R7 mask f5", rd5, 32'hFFFF_EFFF);
    check("R7 mask f4", rd4, 32'hFFFF_FFFF);
    req(1, mr(4, 0), 32'h0000_1234);
    req(0, mr(6, 0), 0);
    check("R8 R6 sts f5", rd5, 32'hFFFF_0FF4);
    check("R8 R6 sts f4", rd4, 32'hFFFF_1FF4);
  endtask

  task automatic t_control();
    req(1, mr(7, 0), 32'h0000_0046);
    check("R9 bp_active", bp5, 4'b1011);
    req(0, mr(7, 0), 0);
    check("R9 ctl readback", rd5, 32'h0000_0046);
    check("R9 bp held on read", bp5, 4'b1011);
    req(1, mr(5, 0), 32'h0000_0001);
    check("R6 slot5 to ctl bp", bp4, 4'b0001);
    req(0, mr(7, 0), 0);
    check("R6 slot5 alias ctl", rd5, 32'h1);
    req(0, mr(4, 0), 0, 0, 0, 0, 1);
    check("R6 de trap f5", exc5, 1);
    check("R6 de no trap f4", exc4, 0);
    check("R6 f4 alias read", rd4, 32'hFFFF_1FF4);
  endtask

  task automatic t_faults();
    req(1, 8'h80, 32'h1111_1111);
    check("R2 ud", exc5, 1);
    req(1, mr(0, 0), 32'h2222_2222, 1, 0, 3);
    check("R3 gp cpl", exc5, 2);
    check("R1 exc rd zero", rd5, 0);
    req(1, mr(0, 0), 32'h3333_3333, 1, 1, 0);
    check("R3 gp v86", exc4, 2);
    req(0, mr(0, 0), 0);
    check("R11 slot0 unchanged", rd5, 32'hFFFF_FFFF);
    req(0, mr(1, 0), 0, 0, 1, 3);
    check("R3 real mode ok", exc5, 0);
    req(0, 8'h40, 0, 1, 0, 3);
    check("R10 form before priv", exc5, 1);
  endtask

  task automatic t_gd();
    req(1, mr(7, 0), 32'h0000_2000);
    check("R9 gd bp", bp5, 0);
    req(0, mr(0, 0), 0, 1, 0, 2);
    check("R10 priv before gd", exc5, 2);
    req(0, mr(4, 0), 0, 0, 0, 0, 1);
    check("R10 gd before alias", exc5, 3);
    check("R4 gd f4", exc4, 3);
    check("R4 no data", rd5, 0);
    req(0, mr(7, 0), 0);
    check("R4 gd cleared", exc5, 0);
    check("R4 ctl now", rd5, 0);
    req(0, mr(6, 0), 0);
    check("R4 bd set f5", rd5, 32'hFFFF_2FF4);
    check("R4 bd set f4", rd4, 32'hFFFF_3FF4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bp_regs();
    t_status();
    t_control();
    t_faults();
    t_gd();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule